// File: doc/BRIEF.md
# Synthesizer Divider Ratio Controller

This block keeps the main-divider ratio of a frequency synthesizer and moves it in response to debounced up and down key pulses. It has two ways of working. In step mode every accepted pulse nudges the ratio by one count, and the ratio is held inside a programmed window. In memory mode the same pulses walk a channel pointer round eight stored slots, and the ratio is taken from the slot the pointer selects. The step-mode ratio is kept untouched while memory mode is active, so leaving memory mode brings back the last stepped value.

When the second oscillator is selected, one of four offset words is added to the ratio with 16-bit wrap-around. A shift below the base ratio is therefore stored as its two's complement. The resulting ratio is registered and goes to a downstream serial loader. A one-cycle strobe tells the loader that a new value is present: once after reset, and again on every later change.

Top module: `divratio_ctrl`

## Requirements
- R1: In synchronous reset (rst_n low) the step ratio loads start_ratio, the channel pointer loads 0 and the registered offset index loads 0. In the first cycle after release, ratio_out shows the start ratio with offset word 0 applied if osc_sel is high, and ratio_vld is high.
- R2: With mem_mode low, a lone key_up pulse raises the step ratio by exactly one and a lone key_down pulse lowers it by exactly one. A pulse sampled at one rising edge appears on ratio_out at the following rising edge.
- R3: In step mode an up pulse has no effect while the step ratio is at or above lim_max, and a down pulse has no effect while it is at or below lim_min. Limits are meant to lie in 40..65535.
- R4: With mem_mode high, up and down pulses move the channel pointer by one and leave the step ratio unchanged. The base ratio is slot i of chan_ratios, bits [16i+15:16i]. When mem_mode returns low, the retained step ratio is output again.
- R5: The channel pointer wraps from 7 to 0 on an up pulse and from 0 to 7 on a down pulse.
- R6: A cycle with key_up and key_down both high changes neither the step ratio nor the channel pointer.
- R7: With osc_sel high, ratio_out = (base + offset word k) mod 65536. Offset word k is bits [16k+15:16k] of ofs_words, and k is ofs_idx registered one cycle earlier. With osc_sel low, ratio_out equals the base.
- R8: ratio_vld is high for exactly the cycles in which ratio_out differs from its value in the previous cycle, plus the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_up | input | 1 | Debounced up pulse, one cycle |
| key_down | input | 1 | Debounced down pulse, one cycle |
| lim_max | input | 16 | Upper ratio limit |
| lim_min | input | 16 | Lower ratio limit |
| start_ratio | input | 16 | Ratio loaded at reset |
| ofs_words | input | 64 | Four offset words, word k at bits [16k+15:16k] |
| chan_ratios | input | 128 | Eight channel ratios, slot i at bits [16i+15:16i] |
| mem_mode | input | 1 | 1 selects memory-channel mode |
| osc_sel | input | 1 | 1 selects the second oscillator, which adds an offset |
| ofs_idx | input | 2 | Offset word selector |
| ratio_out | output | 16 | Registered divider ratio |
| ratio_vld | output | 1 | One-cycle strobe for a new ratio |

## Verification
A step register that slips past a limit, or that moves while memory mode is active, shows on ratio_out one cycle after the key pulse. It shows again when the block returns to step mode, as a value different from the one before the excursion. A channel pointer that fails to wrap selects the wrong slot, and ratio_out shows this on the edge after the pulse. A stale offset index or a lost carry discard gives a wrong sum two cycles after ofs_idx changes. A strobe that is missing, or that fires while the value is unchanged, shows on ratio_vld in the very cycle it should rise or stay low.

// File: rtl/divratio_pkg.sv
`timescale 1ns/1ps
package divratio_pkg;
  localparam int RATIO_W = 16;
  typedef logic [RATIO_W-1:0] ratio_t;

  // key event after the conflict rule has been applied
  typedef enum logic [1:0] {KEY_NONE = 2'd0, KEY_UP = 2'd1, KEY_DN = 2'd2} key_evt_e;

  function automatic key_evt_e decode_keys(input logic up, input logic dn);
    if (up && !dn) return KEY_UP;
    if (dn && !up) return KEY_DN;
    return KEY_NONE;
  endfunction

  // one-count step held inside [lo, hi]
  function automatic ratio_t clamp_step(input ratio_t cur, input key_evt_e ev,
                                        input ratio_t hi, input ratio_t lo);
    case (ev)
      KEY_UP:  return (cur < hi) ? ratio_t'(cur + 1'b1) : cur;
      KEY_DN:  return (cur > lo) ? ratio_t'(cur - 1'b1) : cur;
      default: return cur;
    endcase
  endfunction

  // circular pointer over count slots
  function automatic int unsigned wrap_next(input int unsigned idx, input key_evt_e ev,
                                            input int unsigned count);
    case (ev)
      KEY_UP:  return (idx == count - 1) ? 0 : idx + 1;
      KEY_DN:  return (idx == 0) ? count - 1 : idx - 1;
      default: return idx;
    endcase
  endfunction

  // unsigned sum, carry out discarded
  function automatic ratio_t mod_add(input ratio_t a, input ratio_t b);
    return ratio_t'(a + b);
  endfunction
endpackage

// File: rtl/divratio_step.sv
`timescale 1ns/1ps
module divratio_step
  import divratio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  key_evt_e ev,
  input  logic     active,
  input  ratio_t   start,
  input  ratio_t   hi,
  input  ratio_t   lo,
  output ratio_t   step_q
);
  // named events for the checks
  logic up_take, dn_take, up_block, dn_block, hold_evt;
  assign up_take  = active && (ev == KEY_UP) && (step_q < hi);
  assign dn_take  = active && (ev == KEY_DN) && (step_q > lo);
  assign up_block = active && (ev == KEY_UP) && (step_q >= hi);
  assign dn_block = active && (ev == KEY_DN) && (step_q <= lo);
  assign hold_evt = !active || (ev == KEY_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n)      step_q <= start;
    else if (active) step_q <= clamp_step(step_q, ev, hi, lo);
  end

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    up_take |=> step_q == ratio_t'($past(step_q) + 1'b1));
  p_step_dn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dn_take |=> step_q == ratio_t'($past(step_q) - 1'b1));
  p_clamp_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    up_block |=> $stable(step_q));
  p_clamp_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dn_block |=> $stable(step_q));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> $stable(step_q));
endmodule

// File: rtl/divratio_chan.sv
`timescale 1ns/1ps
module divratio_chan
  import divratio_pkg::*;
#(
  parameter int NUM_CHAN = 8,
  localparam int CHAN_IW = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  key_evt_e                    ev,
  input  logic                        active,
  input  logic [NUM_CHAN*RATIO_W-1:0] slots,
  output logic [CHAN_IW-1:0]          idx_q,
  output ratio_t                      base
);
  localparam logic [CHAN_IW-1:0] LAST = CHAN_IW'(NUM_CHAN - 1);

  ratio_t slot_arr [NUM_CHAN];
  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_slot
    assign slot_arr[i] = slots[i*RATIO_W +: RATIO_W];
  end

  logic wrap_up, wrap_dn, move_up, hold_evt;
  assign wrap_up  = active && (ev == KEY_UP) && (idx_q == LAST);
  assign wrap_dn  = active && (ev == KEY_DN) && (idx_q == '0);
  assign move_up  = active && (ev == KEY_UP) && (idx_q != LAST);
  assign hold_evt = !active || (ev == KEY_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (active) idx_q <= CHAN_IW'(wrap_next(int'(idx_q), ev, NUM_CHAN));
  end

  assign base = slot_arr[idx_q];

  p_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_up |=> idx_q == '0);
  p_wrap_dn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_dn |=> idx_q == LAST);
  p_scroll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    move_up |=> idx_q == CHAN_IW'($past(idx_q) + 1'b1));
  p_chan_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> $stable(idx_q));
endmodule

// File: rtl/divratio_out.sv
`timescale 1ns/1ps
module divratio_out
  import divratio_pkg::*;
#(
  parameter int NUM_OFS = 4,
  localparam int OFS_IW = (NUM_OFS > 1) ? $clog2(NUM_OFS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ratio_t                     base,
  input  logic                       osc_sel,
  input  logic [OFS_IW-1:0]          ofs_idx,
  input  logic [NUM_OFS*RATIO_W-1:0] ofs_words,
  output ratio_t                     ratio_q,
  output logic                       vld_q
);
  ratio_t ofs_arr [NUM_OFS];
  for (genvar k = 0; k < NUM_OFS; k++) begin : g_ofs
    assign ofs_arr[k] = ofs_words[k*RATIO_W +: RATIO_W];
  end

  logic [OFS_IW-1:0] ofs_sel_q;
  logic              first_q;
  ratio_t            target;
  logic              changed;

  assign target  = osc_sel ? mod_add(base, ofs_arr[ofs_sel_q]) : base;
  assign changed = (target != ratio_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_sel_q <= '0;
      first_q   <= 1'b1;
      ratio_q   <= '0;
      vld_q     <= 1'b0;
    end else begin
      ofs_sel_q <= ofs_idx;
      first_q   <= 1'b0;
      ratio_q   <= target;
      vld_q     <= first_q || changed;
    end
  end

  p_first_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |-> ofs_sel_q == '0);
  p_first_vld_r1: assert property (@(posedge clk) disable iff (!rst_n)
    first_q |=> vld_q);
  p_vld_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_q) |-> vld_q);
  p_vld_only_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !$past(first_q)) |-> !$stable(ratio_q));
endmodule

// File: rtl/divratio_ctrl.sv
`timescale 1ns/1ps
module divratio_ctrl
  import divratio_pkg::*;
#(
  parameter int NUM_OFS  = 4,
  parameter int NUM_CHAN = 8,
  localparam int OFS_IW  = (NUM_OFS > 1) ? $clog2(NUM_OFS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        key_up,
  input  logic                        key_down,
  input  logic [RATIO_W-1:0]          lim_max,
  input  logic [RATIO_W-1:0]          lim_min,
  input  logic [RATIO_W-1:0]          start_ratio,
  input  logic [NUM_OFS*RATIO_W-1:0]  ofs_words,
  input  logic [NUM_CHAN*RATIO_W-1:0] chan_ratios,
  input  logic                        mem_mode,
  input  logic                        osc_sel,
  input  logic [OFS_IW-1:0]           ofs_idx,
  output logic [RATIO_W-1:0]          ratio_out,
  output logic                        ratio_vld
);
  localparam int CHAN_IW = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

  key_evt_e           key_ev;
  ratio_t             step_ratio;
  ratio_t             chan_base;
  ratio_t             base_ratio;
  logic [CHAN_IW-1:0] chan_idx;

  assign key_ev     = decode_keys(key_up, key_down);
  assign base_ratio = mem_mode ? chan_base : step_ratio;

  divratio_step u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (key_ev),
    .active (!mem_mode),
    .start  (start_ratio),
    .hi     (lim_max),
    .lo     (lim_min),
    .step_q (step_ratio)
  );

  divratio_chan #(.NUM_CHAN(NUM_CHAN)) u_chan (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (key_ev),
    .active (mem_mode),
    .slots  (chan_ratios),
    .idx_q  (chan_idx),
    .base   (chan_base)
  );

  divratio_out #(.NUM_OFS(NUM_OFS)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .base      (base_ratio),
    .osc_sel   (osc_sel),
    .ofs_idx   (ofs_idx),
    .ofs_words (ofs_words),
    .ratio_q   (ratio_out),
    .vld_q     (ratio_vld)
  );

  p_mem_keeps_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_mode |=> $stable(step_ratio));
  p_step_keeps_chan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_mode |=> $stable(chan_idx));
endmodule

// File: tb/divratio_ctrl_bench.sv
`timescale 1ns/1ps
module divratio_ctrl_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_up = 1'b0, key_down = 1'b0;
  logic [15:0]  lim_max = 16'd2010, lim_min = 16'd2000, start_ratio = 16'd2005;
  logic [63:0]  ofs_words;
  logic [127:0] chan_ratios;
  logic         mem_mode = 1'b0, osc_sel = 1'b0;
  logic [1:0]   ofs_idx = 2'd0;
  logic [15:0]  ratio_out;
  logic         ratio_vld;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_step, m_chan, m_k, m_prev;
  int ofs_val [4] = '{428, 65108, 452, 100};
  int slot_val [8];

  always #2.5 clk = ~clk;

  divratio_ctrl u_divratio_ctrl (
    .clk(clk), .rst_n(rst_n), .key_up(key_up), .key_down(key_down),
    .lim_max(lim_max), .lim_min(lim_min), .start_ratio(start_ratio),
    .ofs_words(ofs_words), .chan_ratios(chan_ratios), .mem_mode(mem_mode),
    .osc_sel(osc_sel), .ofs_idx(ofs_idx), .ratio_out(ratio_out), .ratio_vld(ratio_vld)
  );

  initial begin
    for (int i = 0; i < 8; i++) slot_val[i] = (i == 5) ? 65535 : 3000 + 11 * i;
    for (int i = 0; i < 8; i++) chan_ratios[i*16 +: 16] = 16'(slot_val[i]);
    for (int k = 0; k < 4; k++) ofs_words[k*16 +: 16] = 16'(ofs_val[k]);
  end

  function automatic int model_out();
    int b;
    b = mem_mode ? slot_val[m_chan] : m_step;
    if (osc_sel) b = (b + ofs_val[m_k]) % 65536;
    return b;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic osc, input logic [1:0] idx);
    rst_n = 1'b0; osc_sel = osc; ofs_idx = idx; mem_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_step = 2005; m_chan = 0; m_k = 0;
    @(negedge clk);
    chk("R1 first ratio", ratio_out, model_out());
    chk("R1 first strobe", ratio_vld, 1);
    m_prev = model_out();
    m_k = idx;
    @(negedge clk);
    chk("R7 index after reset", ratio_out, model_out());
    chk("R8 strobe after reset", ratio_vld, (model_out() != m_prev) ? 1 : 0);
    m_prev = model_out();
  endtask

  task automatic pulse(input logic up, input logic dn, input string req);
    key_up = up; key_down = dn;
    @(negedge clk);
    chk("R8 quiet before update", ratio_vld, 0);
    key_up = 1'b0; key_down = 1'b0;
    if (!(up && dn)) begin
      if (mem_mode) m_chan = up ? (m_chan + 1) % 8 : (m_chan + 7) % 8;
      else if (up && m_step < 2010) m_step++;
      else if (dn && m_step > 2000) m_step--;
    end
    @(negedge clk);
    chk(req, ratio_out, model_out());
    chk({req, " R8 strobe"}, ratio_vld, (model_out() != m_prev) ? 1 : 0);
    m_prev = model_out();
  endtask

  task automatic set_mode(input logic m, input string req);
    mem_mode = m;
    @(negedge clk);
    chk(req, ratio_out, model_out());
    chk("R8 mode strobe", ratio_vld, (model_out() != m_prev) ? 1 : 0);
    m_prev = model_out();
  endtask

  task automatic set_offset(input logic osc, input logic [1:0] idx, input string req);
    osc_sel = osc; ofs_idx = idx;
    repeat (2) @(negedge clk);
    m_k = idx;
    chk(req, ratio_out, model_out());
    @(negedge clk);
    chk("R8 settled strobe", ratio_vld, 0);
    m_prev = model_out();
  endtask

  initial begin
    do_reset(1'b0, 2'd0);
    @(negedge clk);
    chk("R8 strobe drops", ratio_vld, 0);
    repeat (3) pulse(1'b1, 1'b0, "R2 step up");
    repeat (3) pulse(1'b1, 1'b0, "R3 up clamp");
    chk("R3 held at max", ratio_out, 2010);
    pulse(1'b1, 1'b1, "R6 both keys step");
    repeat (11) pulse(1'b0, 1'b1, "R2 R3 step down");
    chk("R3 held at min", ratio_out, 2000);
    pulse(1'b1, 1'b0, "R2 up from min");
    set_mode(1'b1, "R4 enter memory");
    pulse(1'b0, 1'b1, "R5 wrap down");
    chk("R5 slot 7", ratio_out, slot_val[7]);
    pulse(1'b1, 1'b0, "R5 wrap up");
    chk("R5 slot 0", ratio_out, slot_val[0]);
    repeat (3) pulse(1'b1, 1'b0, "R4 scroll");
    pulse(1'b1, 1'b1, "R6 both keys memory");
    chk("R4 slot 3", ratio_out, slot_val[3]);
    set_mode(1'b0, "R4 step ratio kept");
    chk("R4 resumed 2001", ratio_out, 2001);
    set_offset(1'b1, 2'd1, "R7 negative offset");
    chk("R7 2001+65108", ratio_out, 1573);
    set_offset(1'b1, 2'd2, "R7 positive offset");
    set_mode(1'b1, "R7 memory with offset");
    repeat (2) pulse(1'b1, 1'b0, "R7 scroll to full slot");
    chk("R7 carry dropped", ratio_out, 451);
    set_offset(1'b0, 2'd3, "R7 offset off");
    do_reset(1'b1, 2'd2);
    chk("R1 R7 start with offset", ratio_out, 2457);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule